// File: doc/BRIEF.md
# Masked Gather/Scatter Sequencer

This block carries out one vector gather (indexed load) or scatter (indexed store) at a time over a memory port that accepts one line-wide request per cycle. A pulse on `start` captures the base address, eight 32-bit lane indices, the lane mask, the scatter data and the current destination contents. Each active lane's byte address is the base plus its index scaled by the 8-byte element size. The sequencer then services the lanes line by line. Every request covers all still-pending lanes whose addresses fall in the same 64-byte line.

Gathered elements collect in a holding buffer. The destination is reported as written only once every active lane is back. A completion mask records the finished lanes. If a request returns a fault, the instruction stops with that request's lanes still open. It can then be started again with the returned mask so the finished lanes are skipped.

The request channel is valid/ready. Once `req_valid` is high, the request stays unchanged until `req_ready` is seen high at a clock edge. Only one request is outstanding at a time. `rsp_ready` is high only while a response is awaited. The memory must return exactly one response per accepted request and must offer it only while `rsp_ready` is high. The control pins (`start`, `busy`, `done`, `fault`) are plain levels and pulses.

Top module: `vgs_seq`

## Requirements
- R1: Lane l's byte address is `base_addr + (index_l << 3)` modulo 2^32, with `base_addr` 8-byte aligned. The line number on `req_addr` is that address shifted right by 6. The 64-bit word within the line is address bits [5:3], and word w occupies bits [64w+63:64w] of `req_wdata` and `rsp_rdata`.
- R2: A lane whose `lane_mask` bit is 0 makes no memory access. Its element of `dst_out` keeps the `dst_in` value captured at start, and a scatter leaves its target word unchanged.
- R3: For a gather, `dst_we` pulses for one cycle together with `done`, only after every active lane's data has returned, and never while lanes are outstanding. `dst_out` then holds the gathered element for every active lane. For a scatter, `dst_we` stays 0.
- R4: When several scatter lanes target the same address, the final memory word is the value of the highest-numbered of those lanes.
- R5: Each request covers the lowest-numbered pending lane together with every other pending lane in the same line, and `req_lanes` shows that group as a bit mask. The number of accepted requests equals the number of distinct lines among the pending lanes; for example, eight lanes spread over five lines take five requests.
- R6: A response with `rsp_fault` = 1 stops the instruction. `fault` goes to 1 and `fault_lane` reports the lowest lane of that request. `busy` drops, `done` stays 0, and `cmask_out` holds exactly the lanes of the earlier, successful requests.
- R7: At start, lanes set in `cmask_in` are treated as finished: they are never requested again, and their held gather data is kept. A restart with `cmask_in` taken from the stopped instruction's `cmask_out` completes the instruction with the same result as an uninterrupted run.
- R8: When all lanes are finished, `done` is high for exactly one cycle, `busy` drops, and `cmask_out` reads 0.
- R9: A request held back by `req_ready` = 0 keeps `req_valid`, `req_addr` and `req_lanes` unchanged until it is accepted.
- R10: After reset, `busy`, `done`, `fault`, `dst_we`, `req_valid` and `cmask_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction; ignored while busy |
| op_scatter | input | 1 | 1 = scatter, 0 = gather |
| base_addr | input | 32 | Byte base address, 8-byte aligned |
| idx_vec | input | 256 | Eight 32-bit lane indices, lane l at bits [32l+31:32l] |
| lane_mask | input | 8 | Active lanes |
| wdata_vec | input | 512 | Scatter data, lane l at bits [64l+63:64l] |
| dst_in | input | 512 | Current destination contents |
| cmask_in | input | 8 | Lanes already finished by an earlier attempt |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle pulse on completion without fault |
| fault | output | 1 | Instruction stopped on a fault; cleared by the next start |
| fault_lane | output | 3 | Lowest lane of the faulting request |
| cmask_out | output | 8 | Completion mask |
| dst_we | output | 1 | Gather destination write pulse |
| dst_out | output | 512 | Destination value (holding buffer) |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_write | output | 1 | 1 = write request |
| req_addr | output | 26 | Line number |
| req_lanes | output | 8 | Lanes served by this request |
| req_wdata | output | 512 | Line write data |
| req_wen | output | 8 | Per-word write enables |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Sequencer awaits a response |
| rsp_fault | input | 1 | Request faulted |
| rsp_rdata | input | 512 | Line read data |

## Verification
Random gathers and scatters use small index ranges, so lanes often share a line or an exact address. A design that split a shared line would issue too many requests. One that merged scatter lanes in the wrong order would leave a lower lane's value in memory. Faults are placed on a randomly chosen active line and checked against the completion mask expected from lowest-lane-first ordering. A restart that re-requested finished lanes, or that lost their gathered data, would show up in the request count or in the final destination. Directed cases cover the five-line coalescing example, the index-to-offset scaling, an all-masked instruction, a one-cycle `done` pulse and random back-pressure on the request channel.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } vgs_state_e;
endpackage

// File: rtl/vgs_addr_gen.sv
module vgs_addr_gen #(
  parameter int LANES  = 8,
  parameter int IDX_W  = 32,
  parameter int ADDR_W = 32,
  parameter int EB_LOG = 3,
  parameter int OFF_W  = 6,
  parameter int SLOT_W = 3,
  parameter int LINE_W = 26
) (
  input  logic [ADDR_W-1:0]        base,
  input  logic [LANES*IDX_W-1:0]   idx_vec,
  output logic [LANES*LINE_W-1:0]  line_vec,
  output logic [LANES*SLOT_W-1:0]  slot_vec
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] scaled;
    logic [ADDR_W-1:0] addr;
    assign scaled = ADDR_W'(idx_vec[l*IDX_W +: IDX_W]) << EB_LOG;
    assign addr   = base + scaled;
    assign line_vec[l*LINE_W +: LINE_W] = addr[ADDR_W-1:OFF_W];
    assign slot_vec[l*SLOT_W +: SLOT_W] = addr[OFF_W-1:EB_LOG];
  end
endmodule

// File: rtl/vgs_group_pick.sv
module vgs_group_pick #(
  parameter int LANES  = 8,
  parameter int LINE_W = 26,
  parameter int LANE_W = 3
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*LINE_W-1:0] line_vec,
  output logic                    any,
  output logic [LANE_W-1:0]       lead,
  output logic [LINE_W-1:0]       lead_line,
  output logic [LANES-1:0]        grp
);
  always_comb begin
    any  = 1'b0;
    lead = '0;
    for (int l = 0; l < LANES; l++) begin
      if (pend[l] && !any) begin
        any  = 1'b1;
        lead = LANE_W'(l);
      end
    end
    lead_line = line_vec[int'(lead)*LINE_W +: LINE_W];
    for (int l = 0; l < LANES; l++) begin
      grp[l] = pend[l] && (line_vec[l*LINE_W +: LINE_W] == lead_line);
    end
  end
endmodule

// File: rtl/vgs_line_pack.sv
module vgs_line_pack #(
  parameter int LANES  = 8,
  parameter int ELEM_W = 64,
  parameter int SLOT_W = 3,
  parameter int WORDS  = 8
) (
  input  logic [LANES-1:0]        grp,
  input  logic [LANES*SLOT_W-1:0] slot_vec,
  input  logic [LANES*ELEM_W-1:0] wdata_vec,
  output logic [WORDS*ELEM_W-1:0] line_wdata,
  output logic [WORDS-1:0]        word_en
);
  // Ascending lane walk: a later lane on the same word overwrites an earlier one.
  always_comb begin
    line_wdata = '0;
    word_en    = '0;
    for (int l = 0; l < LANES; l++) begin
      if (grp[l]) begin
        line_wdata[int'(slot_vec[l*SLOT_W +: SLOT_W])*ELEM_W +: ELEM_W] =
          wdata_vec[l*ELEM_W +: ELEM_W];
        word_en[slot_vec[l*SLOT_W +: SLOT_W]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vgs_seq.sv
module vgs_seq
  import vgs_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int IDX_W      = 32,
  parameter int ELEM_W     = 64,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          start,
  input  logic                                          op_scatter,
  input  logic [ADDR_W-1:0]                             base_addr,
  input  logic [LANES*IDX_W-1:0]                        idx_vec,
  input  logic [LANES-1:0]                              lane_mask,
  input  logic [LANES*ELEM_W-1:0]                       wdata_vec,
  input  logic [LANES*ELEM_W-1:0]                       dst_in,
  input  logic [LANES-1:0]                              cmask_in,
  output logic                                          busy,
  output logic                                          done,
  output logic                                          fault,
  output logic [$clog2(LANES)-1:0]                      fault_lane,
  output logic [LANES-1:0]                              cmask_out,
  output logic                                          dst_we,
  output logic [LANES*ELEM_W-1:0]                       dst_out,
  output logic                                          req_valid,
  input  logic                                          req_ready,
  output logic                                          req_write,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]          req_addr,
  output logic [LANES-1:0]                              req_lanes,
  output logic [LINE_BYTES*8-1:0]                       req_wdata,
  output logic [LINE_BYTES/(ELEM_W/8)-1:0]              req_wen,
  input  logic                                          rsp_valid,
  output logic                                          rsp_ready,
  input  logic                                          rsp_fault,
  input  logic [LINE_BYTES*8-1:0]                       rsp_rdata
);
  localparam int EB     = ELEM_W / 8;
  localparam int EB_LOG = $clog2(EB);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SLOT_W = OFF_W - EB_LOG;
  localparam int WORDS  = LINE_BYTES / EB;
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int LANE_W = $clog2(LANES);

  vgs_state_e                state;
  logic [ADDR_W-1:0]         base_q;
  logic [LANES*IDX_W-1:0]    idx_q;
  logic [LANES*ELEM_W-1:0]   wd_q;
  logic                      scat_q;
  logic [LANES-1:0]          pend;
  logic [LANES-1:0]          cmask;
  logic [LANES*ELEM_W-1:0]   hold;
  logic [LANES-1:0]          grp_q;
  logic [LANE_W-1:0]         lead_q;

  logic [LANES*LINE_W-1:0]   line_vec;
  logic [LANES*SLOT_W-1:0]   slot_vec;
  logic                      any;
  logic [LANE_W-1:0]         lead;
  logic [LINE_W-1:0]         lead_line;
  logic [LANES-1:0]          grp;
  logic [WORDS*ELEM_W-1:0]   pack_data;
  logic [WORDS-1:0]          pack_en;

  vgs_addr_gen #(
    .LANES(LANES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .EB_LOG(EB_LOG),
    .OFF_W(OFF_W), .SLOT_W(SLOT_W), .LINE_W(LINE_W)
  ) u_addr (
    .base(base_q), .idx_vec(idx_q), .line_vec(line_vec), .slot_vec(slot_vec)
  );

  vgs_group_pick #(.LANES(LANES), .LINE_W(LINE_W), .LANE_W(LANE_W)) u_pick (
    .pend(pend), .line_vec(line_vec), .any(any), .lead(lead),
    .lead_line(lead_line), .grp(grp)
  );

  vgs_line_pack #(.LANES(LANES), .ELEM_W(ELEM_W), .SLOT_W(SLOT_W), .WORDS(WORDS)) u_pack (
    .grp(grp), .slot_vec(slot_vec), .wdata_vec(wd_q),
    .line_wdata(pack_data), .word_en(pack_en)
  );

  assign busy      = (state != ST_IDLE);
  assign rsp_ready = (state == ST_WAIT);
  assign req_valid = (state == ST_ISSUE) && any;
  assign req_write = scat_q;
  assign req_addr  = lead_line;
  assign req_lanes = grp;
  assign req_wdata = pack_data;
  assign req_wen   = scat_q ? pack_en : '0;
  assign cmask_out = cmask;
  assign dst_out   = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      base_q     <= '0;
      idx_q      <= '0;
      wd_q       <= '0;
      scat_q     <= 1'b0;
      pend       <= '0;
      cmask      <= '0;
      hold       <= '0;
      grp_q      <= '0;
      lead_q     <= '0;
      done       <= 1'b0;
      dst_we     <= 1'b0;
      fault      <= 1'b0;
      fault_lane <= '0;
    end else begin
      done   <= 1'b0;
      dst_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            base_q <= base_addr;
            idx_q  <= idx_vec;
            wd_q   <= wdata_vec;
            scat_q <= op_scatter;
            pend   <= lane_mask & ~cmask_in;
            cmask  <= cmask_in;
            fault  <= 1'b0;
            for (int l = 0; l < LANES; l++) begin
              if (!cmask_in[l]) hold[l*ELEM_W +: ELEM_W] <= dst_in[l*ELEM_W +: ELEM_W];
            end
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (!any) begin
            cmask  <= '0;
            done   <= 1'b1;
            dst_we <= !scat_q;
            state  <= ST_IDLE;
          end else if (req_ready) begin
            grp_q  <= grp;
            lead_q <= lead;
            state  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (rsp_fault) begin
              fault      <= 1'b1;
              fault_lane <= lead_q;
              pend       <= '0;
              state      <= ST_IDLE;
            end else begin
              cmask <= cmask | grp_q;
              pend  <= pend & ~grp_q;
              if (!scat_q) begin
                for (int l = 0; l < LANES; l++) begin
                  if (grp_q[l]) begin
                    hold[l*ELEM_W +: ELEM_W] <=
                      rsp_rdata[int'(slot_vec[l*SLOT_W +: SLOT_W])*ELEM_W +: ELEM_W];
                  end
                end
              end
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: a stalled request holds still
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_lanes)));

  // R7: finished lanes are never requested again
  a_r7_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req_lanes & cmask_out) == '0));

  // R8: done is a single-cycle pulse with a cleared completion mask
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmask_out == '0 && !busy));

  // R3: the destination write only accompanies completion
  a_r3_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> done);

  // R6: a fault never coincides with completion
  a_r6_fault_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !done);

  // R5: the request group always contains its lowest-lane leader
  a_r5_lead_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_lanes != '0));
endmodule

// File: tb/vgs_seq_bench.sv
module vgs_seq_bench;
  localparam int L = 8;
  localparam int MW = 1024;

  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic             start = 0, op_scatter = 0;
  logic [31:0]      base_addr = 0;
  logic [L*32-1:0]  idx_vec = '0;
  logic [L-1:0]     lane_mask = '0, cmask_in = '0;
  logic [L*64-1:0]  wdata_vec = '0, dst_in = '0;
  logic             busy, done, fault, dst_we;
  logic [2:0]       fault_lane;
  logic [L-1:0]     cmask_out, req_lanes;
  logic [L*64-1:0]  dst_out;
  logic             req_valid, req_write, rsp_ready;
  logic             req_ready = 1, rsp_valid = 0, rsp_fault = 0;
  logic [25:0]      req_addr;
  logic [511:0]     req_wdata, rsp_rdata = '0;
  logic [7:0]       req_wen;

  vgs_seq u_vgs_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_scatter(op_scatter),
    .base_addr(base_addr), .idx_vec(idx_vec), .lane_mask(lane_mask),
    .wdata_vec(wdata_vec), .dst_in(dst_in), .cmask_in(cmask_in),
    .busy(busy), .done(done), .fault(fault), .fault_lane(fault_lane),
    .cmask_out(cmask_out), .dst_we(dst_we), .dst_out(dst_out),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_lanes(req_lanes), .req_wdata(req_wdata),
    .req_wen(req_wen), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata)
  );

  int vectors = 0, miscompares = 0;
  int cycles = 0, req_cnt = 0;
  logic [63:0] mem [MW];
  logic [63:0] shadow [MW];
  bit bp_en = 0, flt_en = 0;
  logic [25:0] flt_line = '0;

  // memory model: one response the cycle after each accepted request
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (req_valid && req_ready) begin
      req_cnt   <= req_cnt + 1;
      rsp_valid <= 1'b1;
      rsp_fault <= flt_en && (req_addr == flt_line);
      for (int w = 0; w < 8; w++) begin
        rsp_rdata[w*64 +: 64] <= mem[(int'(req_addr)*8 + w) % MW];
        if (req_write && req_wen[w] && !(flt_en && req_addr == flt_line))
          mem[(int'(req_addr)*8 + w) % MW] <= req_wdata[w*64 +: 64];
      end
    end
    req_ready <= bp_en ? 1'($urandom % 2) : 1'b1;
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected <150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic logic [31:0] laddr(input int l);
    return base_addr + (idx_vec[l*32 +: 32] << 3);
  endfunction

  function automatic int nlines(input logic [L-1:0] m);
    int n = 0;
    for (int a = 0; a < L; a++) begin
      bit seen = 0;
      if (!m[a]) continue;
      for (int b = 0; b < a; b++)
        if (m[b] && laddr(b)[31:6] == laddr(a)[31:6]) seen = 1;
      if (!seen) n++;
    end
    return n;
  endfunction

  // outcome: 0 done, 1 fault, 2 timeout
  task automatic run_op(output int outcome, output bit early_we);
    int t = 0;
    early_we = 0;
    @(negedge clk);
    req_cnt = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    outcome = 2;
    while (t < 3000) begin
      if (done) begin outcome = 0; break; end
      if (fault) begin outcome = 1; break; end
      if (dst_we) early_we = 1;
      @(negedge clk);
      t++;
    end
    if (outcome == 2) chk(0, "R8 timeout", 64'(t), 64'd0);
  endtask

  // full gather/scatter with expected values; cin gives pre-finished lanes
  task automatic do_trial(input bit scat, input bit inject);
    int oc; bit ew;
    logic [L*64-1:0] exp_dst;
    logic [L-1:0] exp_cm;
    int flead;
    op_scatter = scat;
    cmask_in = '0;
    for (int i = 0; i < MW; i++) shadow[i] = mem[i];
    for (int l = 0; l < L; l++) begin
      exp_dst[l*64 +: 64] = (lane_mask[l] && !scat) ? mem[(laddr(l) >> 3) % MW] : dst_in[l*64 +: 64];
      if (lane_mask[l] && scat) shadow[(laddr(l) >> 3) % MW] = wdata_vec[l*64 +: 64];
    end
    flt_en = 0;
    flead = -1;
    if (inject && lane_mask != 0) begin
      int pick;
      do pick = $urandom % L; while (!lane_mask[pick]);
      flt_line = laddr(pick)[31:6];
      flt_en = 1;
      for (int l = L-1; l >= 0; l--)
        if (lane_mask[l] && laddr(l)[31:6] == flt_line) flead = l;
      exp_cm = '0;
      for (int l = 0; l < L; l++) begin
        int ld = l;
        if (!lane_mask[l]) continue;
        for (int b = 0; b < l; b++)
          if (lane_mask[b] && laddr(b)[31:6] == laddr(l)[31:6] && b < ld) ld = b;
        if (ld < flead) exp_cm[l] = 1;
      end
      run_op(oc, ew);
      chk(oc == 1, "R6 fault stop", 64'(oc), 64'd1);
      chk(fault_lane == 3'(flead), "R6 fault lane", 64'(fault_lane), 64'(flead));
      chk(cmask_out == exp_cm, "R6 completion mask", 64'(cmask_out), 64'(exp_cm));
      chk(!busy && !dst_we, "R6 stopped idle", 64'(busy), 64'd0);
      flt_en = 0;
      cmask_in = cmask_out;
    end
    run_op(oc, ew);
    chk(oc == 0, "R8 done reached", 64'(oc), 64'd0);
    chk(req_cnt == nlines(lane_mask & ~cmask_in), "R5/R7 request count",
        64'(req_cnt), 64'(nlines(lane_mask & ~cmask_in)));
    chk(cmask_out == 0 && !busy, "R8 mask cleared", 64'(cmask_out), 64'd0);
    chk(dst_we == !scat && !ew, "R3 dst write timing", 64'(dst_we), 64'(!scat));
    if (!scat) begin
      for (int l = 0; l < L; l++)
        chk(dst_out[l*64 +: 64] == exp_dst[l*64 +: 64],
            lane_mask[l] ? "R3 gathered lane" : "R2 masked lane kept",
            dst_out[l*64 +: 64], exp_dst[l*64 +: 64]);
    end else begin
      for (int i = 0; i < MW; i++)
        if (mem[i] !== shadow[i])
          chk(0, "R4/R2 scatter memory", mem[i], shadow[i]);
      chk(1, "R4 scatter memory", 64'd0, 64'd0);
    end
    @(negedge clk);
    chk(!done, "R8 done one cycle", 64'(done), 64'd0);
    cmask_in = '0;
  endtask

  initial begin
    for (int i = 0; i < MW; i++) mem[i] = {$urandom, $urandom};
    #20;
    @(negedge clk);
    chk(!busy && !done && !fault && !dst_we && !req_valid && cmask_out == 0,
        "R10 reset state", {busy, done, fault, dst_we, req_valid}, 64'd0);
    rst_n = 1;

    // R1: index 2 of 8-byte elements lands at base+0x10
    base_addr = 32'h1000; idx_vec = '0; idx_vec[31:0] = 32'd2; lane_mask = 8'h01;
    dst_in = '0;
    do_trial(0, 0);
    chk(dst_out[63:0] == mem[(32'h1010 >> 3)], "R1 scaled offset", dst_out[63:0], mem[32'h1010 >> 3]);

    // R5: eight lanes over five lines
    begin
      int ix[8] = '{0, 1, 8, 9, 16, 24, 25, 32};
      for (int l = 0; l < L; l++) idx_vec[l*32 +: 32] = 32'(ix[l]);
      lane_mask = 8'hFF;
      do_trial(0, 0);
      chk(req_cnt == 5, "R5 five-line example", 64'(req_cnt), 64'd5);
    end

    // R2: everything masked
    lane_mask = 8'h00;
    for (int l = 0; l < L; l++) dst_in[l*64 +: 64] = {$urandom, $urandom};
    do_trial(0, 0);
    chk(req_cnt == 0, "R2 no access when masked", 64'(req_cnt), 64'd0);

    // R4: all lanes on one address
    for (int l = 0; l < L; l++) begin
      idx_vec[l*32 +: 32] = 32'd5;
      wdata_vec[l*64 +: 64] = 64'(l) + 64'hA000;
    end
    lane_mask = 8'hFF;
    do_trial(1, 0);
    chk(mem[(32'h1028 >> 3)] == 64'hA007, "R4 highest lane wins", mem[32'h1028 >> 3], 64'hA007);
    chk(req_cnt == 1, "R5 single line", 64'(req_cnt), 64'd1);

    // random sweep with back-pressure and faults
    for (int t = 0; t < 600; t++) begin
      bp_en = t[0];
      base_addr = 32'(($urandom % 448) * 8);
      for (int l = 0; l < L; l++) begin
        idx_vec[l*32 +: 32] = 32'($urandom % ((t % 3 == 0) ? 8 : 64));
        wdata_vec[l*64 +: 64] = {$urandom, $urandom};
        dst_in[l*64 +: 64] = {$urandom, $urandom};
      end
      lane_mask = 8'($urandom);
      do_trial(t[1], (t % 4) >= 2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule